// File: doc/BRIEF.md
# Clock Source Selector with Failure Fallback

The block picks the system clock from two sources: an internal RC reference that is always present and an external crystal clock that software can ask for. After reset the internal clock drives the output. When software raises the select request, the output hands over to the external clock through a pair of enable chains, one per clock domain. Each chain lets its clock through only after the other chain has shut its own clock off, so the output never shows a shortened high or low phase.

While the external clock is requested and monitoring is enabled, the internal domain counts internal cycles between external edges. An external toggle flop is synchronized into the internal domain for this count. If `WINDOW` internal cycles pass with no external edge, a sticky failure flag is set. The flag clears the external enable chain asynchronously, because that chain's own clock may have stopped, and the output returns to the internal clock. An interrupt follows the flag when interrupts are enabled. The external clock cannot be chosen again until software pulses the flag-clear input.

Top module: `clksrc_sel`

## Requirements
- R1: After reset, `sys_clk` runs at the internal clock rate, and `src_ext`, `fail_flag` and `irq` are all 0.
- R2: With `sel_ext_req`=1, a running external clock and no failure, `sys_clk` follows the external clock and `src_ext` reads 1 once the switch is complete.
- R3: No high or low phase of `sys_clk` is shorter than the shorter half period of the two source clocks, including during switches and fallback.
- R4: With `mon_en`=1 and the external clock requested, the absence of any external edge for `WINDOW` (default 8) internal cycles sets `fail_flag` to 1, and `sys_clk` returns to the internal clock with `src_ext`=0. This also applies when the external clock never starts after the request.
- R5: `irq` equals `fail_flag` when `irq_en`=1 and is 0 when `irq_en`=0.
- R6: `fail_flag` stays 1 until it is cleared. While it is set, the external clock is not reselected, even if `sel_ext_req`=1 and the external clock is running again.
- R7: Holding `fail_clr`=1 for one internal cycle clears `fail_flag`. After that the selection follows `sel_ext_req` again.
- R8: With `mon_en`=0, no failure is declared, even when the external clock stops.
- R9: Dropping `sel_ext_req` to 0 returns `sys_clk` to the internal clock, and `src_ext` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC reference clock; the monitor and the status logic run on it |
| clk_ext | input | 1 | External crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk_int |
| sel_ext_req | input | 1 | Software request for the external source (1 = external) |
| mon_en | input | 1 | Enables failure monitoring of the external clock |
| irq_en | input | 1 | Enables the failure interrupt |
| fail_clr | input | 1 | Clears the sticky failure flag (clk_int domain) |
| sys_clk | output | 1 | Glitch-free selected system clock |
| src_ext | output | 1 | 1 once the external clock drives sys_clk, 0 for the internal clock |
| fail_flag | output | 1 | Sticky external clock failure flag |
| irq | output | 1 | Failure interrupt |

## Verification
The hardest case to reach is a loss of the external clock while the output is already running from it. The stopped clock then can no longer advance its own enable chain, and only the asynchronous clear from the failure flag can release the output. The bench drives the external clock from a generator that stops only after a completed low phase. It stops the generator while the external source is selected, and also before the external source is ever selected. In both cases it checks that the output falls back to the internal rate with no short phase. A sweep over external periods, interrupt enable and monitor enable covers the remaining combinations.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int CKS_SYNC_STAGES = 2;
  localparam int CKS_WINDOW      = 8;

  typedef enum logic {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } src_e;
endpackage

// File: rtl/cks_sync.sv
module cks_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_nxt;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/cks_gate_chain.sv
// Enable chain for one clock: a rising-edge capture stage followed by a
// falling-edge stage, so the enable only changes while the clock is low.
module cks_gate_chain #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic en
);
  logic cap_q, cap_nxt;
  logic en_q, en_nxt;

  always_comb begin
    cap_nxt = d;
    en_nxt  = cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= RST_VAL;
    else        cap_q <= cap_nxt;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= RST_VAL;
    else        en_q <= en_nxt;
  end

  assign en = en_q;
endmodule

// File: rtl/cks_monitor.sv
// Counts internal cycles since the last external edge; sets a sticky flag
// when the count reaches WINDOW without an edge.
module cks_monitor #(
  parameter int WINDOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_s,
  input  logic active,
  input  logic clr,
  output logic fail
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic          tog_d_q, tog_d_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          fail_q, fail_nxt;
  logic          ext_edge, fail_set;

  always_comb begin
    ext_edge  = tog_s ^ tog_d_q;
    tog_d_nxt = tog_s;
    fail_set  = active && !ext_edge && (cnt_q == LAST);
    if (!active || ext_edge)  cnt_nxt = '0;
    else if (cnt_q != LAST)   cnt_nxt = cnt_q + 1'b1;
    else                      cnt_nxt = cnt_q;
    fail_nxt = fail_set || (fail_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d_q <= 1'b0;
      cnt_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      tog_d_q <= tog_d_nxt;
      cnt_q   <= cnt_nxt;
      fail_q  <= fail_nxt;
    end
  end

  assign fail = fail_q;
endmodule

// File: rtl/clksrc_sel.sv
module clksrc_sel
  import clksrc_pkg::*;
#(
  parameter int WINDOW      = CKS_WINDOW,
  parameter int SYNC_STAGES = CKS_SYNC_STAGES
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic sel_ext_req,
  input  logic mon_en,
  input  logic irq_en,
  input  logic fail_clr,
  output logic sys_clk,
  output logic src_ext,
  output logic fail_flag,
  output logic irq
);
  logic rst_n_s;
  logic ext_clr_n;
  logic want_ext;
  logic int_en, ext_en, ext_en_s;
  logic tog_q, tog_nxt, tog_s;
  logic fail_w;
  src_e cur_src;

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk_int), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  assign want_ext  = sel_ext_req & ~fail_w;
  assign ext_clr_n = rst_n_s & ~fail_w;

  // external-domain activity toggle
  always_comb tog_nxt = ~tog_q;

  always_ff @(posedge clk_ext or negedge rst_n_s) begin
    if (!rst_n_s) tog_q <= 1'b0;
    else          tog_q <= tog_nxt;
  end

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
    .clk(clk_int), .rst_n(rst_n_s), .d(tog_q), .q(tog_s)
  );

  cks_monitor #(.WINDOW(WINDOW)) u_mon (
    .clk(clk_int), .rst_n(rst_n_s), .tog_s(tog_s),
    .active(mon_en & want_ext), .clr(fail_clr), .fail(fail_w)
  );

  cks_gate_chain #(.RST_VAL(1'b1)) u_int_chain (
    .clk(clk_int), .rst_n(rst_n_s), .d(~want_ext & ~ext_en), .en(int_en)
  );

  cks_gate_chain #(.RST_VAL(1'b0)) u_ext_chain (
    .clk(clk_ext), .rst_n(ext_clr_n), .d(want_ext & ~int_en), .en(ext_en)
  );

  cks_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_src_sync (
    .clk(clk_int), .rst_n(rst_n_s), .d(ext_en), .q(ext_en_s)
  );

  assign cur_src   = ext_en_s ? SRC_EXT : SRC_INT;
  assign src_ext   = (cur_src == SRC_EXT);
  assign sys_clk   = (clk_int & int_en) | (clk_ext & ext_en);
  assign fail_flag = fail_w;
  assign irq       = fail_w & irq_en;
endmodule

// File: rtl/clksrc_sel_chk.sv
module clksrc_sel_chk (
  input logic clk_int,
  input logic rst_n,
  input logic mon_en,
  input logic irq_en,
  input logic fail_clr,
  input logic src_ext,
  input logic fail_flag,
  input logic irq,
  input logic int_en,
  input logic ext_en
);
  // R3
  enables_onehot_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $onehot0({int_en, ext_en}));

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    irq |-> fail_flag);

  // R5
  irq_masked_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R6
  flag_sticky_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (fail_flag && !fail_clr) |=> fail_flag);

  // R6
  no_reselect_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(src_ext) |-> !$past(fail_flag));

  // R7
  clear_cause_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $fell(fail_flag) |-> $past(fail_clr));

  // R8
  set_needs_mon_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(mon_en));
endmodule

bind clksrc_sel clksrc_sel_chk i_chk (
  .clk_int(clk_int), .rst_n(rst_n), .mon_en(mon_en), .irq_en(irq_en),
  .fail_clr(fail_clr), .src_ext(src_ext), .fail_flag(fail_flag), .irq(irq),
  .int_en(int_en), .ext_en(ext_en)
);

// File: tb/test_clksrc_sel.sv
`timescale 1ns/1ps
module test_clksrc_sel;
  logic clk_int = 1'b0;
  logic clk_ext = 1'b0;
  logic rst_n = 1'b0;
  logic sel_ext_req = 1'b0, mon_en = 1'b0, irq_en = 1'b0, fail_clr = 1'b0;
  logic sys_clk, src_ext, fail_flag, irq;

  int checks = 0, failures = 0;
  real ext_half = 6.0;
  logic ext_run = 1'b0;
  int edge_cnt = 0;
  real last_t = 0.0, min_hi = 1.0e9, min_lo = 1.0e9;
  logic meas_on = 1'b0;
  bit done = 1'b0;

  clksrc_sel i_clksrc_sel (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n),
    .sel_ext_req(sel_ext_req), .mon_en(mon_en), .irq_en(irq_en),
    .fail_clr(fail_clr), .sys_clk(sys_clk), .src_ext(src_ext),
    .fail_flag(fail_flag), .irq(irq)
  );

  always #4 clk_int = ~clk_int;

  // external generator: stops only after a full low phase
  initial forever begin
    #(ext_half);
    if (clk_ext) clk_ext = 1'b0;
    else if (ext_run) clk_ext = 1'b1;
  end

  always @(posedge sys_clk) edge_cnt++;

  always @(sys_clk) begin
    if (meas_on) begin
      if (sys_clk == 1'b0) begin
        if ($realtime - last_t < min_hi) min_hi = $realtime - last_t;
      end else begin
        if ($realtime - last_t < min_lo) min_lo = $realtime - last_t;
      end
    end
    last_t = $realtime;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rate(input string req, input int exp);
    int got;
    edge_cnt = 0;
    #400;
    got = edge_cnt;
    checks++;
    if (got < exp - 1 || got > exp + 1) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk_int) fail_clr = 1'b1;
    @(negedge clk_int) fail_clr = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk_int);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_int);
    #1;
    meas_on = 1'b1;
    // R1 reset state
    chk("R1 src_ext", src_ext, 0);
    chk("R1 fail_flag", fail_flag, 0);
    chk("R1 irq", irq, 0);
    chk_rate("R1 rate", 50);

    // R2 / R9 sweep of external periods
    ext_run = 1'b1;
    for (int h = 5; h <= 10; h++) begin
      if (h == 7 || h == 9) continue;
      ext_half = h;
      @(negedge clk_int) sel_ext_req = 1'b1;
      #300;
      chk("R2 src_ext", src_ext, 1);
      chk_rate("R2 rate", 400 / (2 * h));
      @(negedge clk_int) sel_ext_req = 1'b0;
      #300;
      chk("R9 src_ext", src_ext, 0);
      chk_rate("R9 rate", 50);
    end

    // R4..R7 failure while selected, both interrupt settings
    ext_half = 6.0;
    for (int ie = 0; ie < 2; ie++) begin
      irq_en = ie[0];
      mon_en = 1'b1;
      @(negedge clk_int) sel_ext_req = 1'b1;
      #300;
      chk("R2 src_ext pre-fail", src_ext, 1);
      chk("R4 no false fail", fail_flag, 0);
      ext_run = 1'b0;
      #400;
      chk("R4 fail_flag", fail_flag, 1);
      chk("R4 src_ext", src_ext, 0);
      chk("R5 irq", irq, ie);
      chk_rate("R4 rate", 50);
      ext_run = 1'b1;
      #300;
      chk("R6 flag held", fail_flag, 1);
      chk("R6 no reselect", src_ext, 0);
      chk_rate("R6 rate", 50);
      pulse_clr();
      #300;
      chk("R7 flag cleared", fail_flag, 0);
      chk("R5 irq cleared", irq, 0);
      chk("R7 reselect", src_ext, 1);
      @(negedge clk_int) sel_ext_req = 1'b0;
      #300;
    end

    // R4 external clock never starts after request
    irq_en = 1'b1;
    ext_run = 1'b0;
    #100;
    @(negedge clk_int) sel_ext_req = 1'b1;
    #500;
    chk("R4 dead-start flag", fail_flag, 1);
    chk("R5 dead-start irq", irq, 1);
    chk_rate("R4 dead-start rate", 50);
    @(negedge clk_int) sel_ext_req = 1'b0;
    pulse_clr();
    ext_run = 1'b1;
    #100;

    // R8 monitor disabled
    mon_en = 1'b0;
    @(negedge clk_int) sel_ext_req = 1'b1;
    #300;
    ext_run = 1'b0;
    #400;
    chk("R8 no fail", fail_flag, 0);
    chk("R8 irq", irq, 0);
    ext_run = 1'b1;
    #300;
    chk("R8 still external", src_ext, 1);
    @(negedge clk_int) sel_ext_req = 1'b0;
    #300;
    chk("R9 back internal", src_ext, 0);

    // R3 pulse widths (in units of 10 ps)
    chk("R3 min high ok", (min_hi >= 3.9) ? 1 : 0, 1);
    chk("R3 min low ok", (min_lo >= 3.9) ? 1 : 0, 1);
    if (min_hi < 3.9 || min_lo < 3.9)
      $display("R3 widths hi=%0d lo=%0d (x10ps)", int'(min_hi * 100), int'(min_lo * 100));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule